// File: doc/BRIEF.md
# SD Command and Response Engine

This block issues a single SD/MMC command on the bidirectional CMD line and gathers the card's answer. Software loads a 6-bit command index and a 32-bit argument, selects the response handling (none, 48-bit or 136-bit), and can ask for the CRC check to be skipped or for 8 idle card clocks to follow the transaction. A one-cycle run strobe then starts the sequence.

Each system clock cycle that the card clock enable is high is one card clock. During that cycle the engine drives one command bit or samples one response bit. The frame is built with its CRC7 in hardware and shifted out MSB first. After the frame, the engine watches for a start bit within a fixed window. It captures the response, checks the CRC7 and the end bit, and latches the response words and three status flags. A busy output covers the whole sequence.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted run sends, in the 48 cycles after the run edge with cmd_oe high, the frame {0, 1, index[5:0], argument[31:0], CRC7, 1}, MSB first. The CRC7 uses polynomial x^7+x^3+1 with a zero seed, over the first 40 bits.
- R2: With resp_expect low, no response is sampled and the sequence ends after the 48 frame cycles, with all three status flags low.
- R3: With resp_expect high and resp_long low, a 48-bit response is taken. Its bits [39:8] go to resp_word0, and resp_word1 to resp_word3 become zero. The CRC7 covers bits [47:8] and is compared with bits [7:1].
- R4: With resp_expect and resp_long high, a 136-bit response is taken. Bits [127:0] are stored raw, resp_word0 holding bits [31:0] with the CRC7 in [7:1] and the end bit in [0]. The CRC7 covers bits [127:8] only, so the start, transmission and 6 reserved bits are not checked.
- R5: A received CRC7 that differs from the computed one sets crc_err.
- R6: With crc_ignore high, crc_err stays low whatever CRC7 arrives.
- R7: A final response bit of 0 sets end_err.
- R8: The response start bit (a 0 on cmd_in) is accepted in any of the 64 card clocks after the frame. If it does not appear, timeout_err is set after those 64 clocks and the response words keep their old values.
- R9: cmd_busy and card_clk_en rise on the run edge and fall when the sequence, including any appended clocks, is over.
- R10: With append8 high, 8 further card clocks with cmd_oe low follow the end of the transaction.
- R11: A run strobe while cmd_busy is high is ignored.
- R12: An accepted run clears crc_err, end_err and timeout_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one card clock per enabled cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_expect | input | 1 | A response is to be collected |
| resp_long | input | 1 | Response is 136 bits instead of 48 |
| crc_ignore | input | 1 | Skip the response CRC7 check |
| append8 | input | 1 | Append 8 idle card clocks |
| run | input | 1 | Start strobe |
| card_clk_en | output | 1 | Card clock enable |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_in | input | 1 | CMD line sampled value |
| resp_word0 | output | 32 | Response word 0 (least significant) |
| resp_word1 | output | 32 | Response word 1 |
| resp_word2 | output | 32 | Response word 2 |
| resp_word3 | output | 32 | Response word 3 (most significant) |
| cmd_busy | output | 1 | Sequence in progress |
| crc_err | output | 1 | Response CRC7 mismatch |
| end_err | output | 1 | Response end bit was 0 |
| timeout_err | output | 1 | No response start bit in the window |

## Verification
Commands are sent with and without responses, in short and long form, with start-bit delays of 2, 5 and 63 clocks and with no start bit at all. This separates window acceptance at its last slot from timeout. Responses carry good CRCs, flipped CRCs with and without the ignore option, and a zero end bit, so each flag is shown to react only to its own fault. Clock counts with and without the 8-clock tail, a second run strobe in mid-frame, and a clean command after a faulty one show that busy, padding, run rejection and flag clearing are independent of the data path.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int FRAME_BITS = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TX,
    ST_RESP,
    ST_PAD
  } eng_state_t;

  // One serial step of CRC7, polynomial x^7 + x^3 + 1
  function automatic logic [6:0] crc7_next(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

  // Full command frame: start, direction, index, argument, CRC7, end
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [5:0] idx,
                                                        input logic [31:0] arg);
    logic [39:0] head;
    logic [6:0]  c;
    head = {2'b01, idx, arg};
    c    = '0;
    for (int i = 39; i >= 0; i--) c = crc7_next(c, head[i]);
    return {head, c, 1'b1};
  endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic        line_out,
  output logic        line_oe,
  output logic        done
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      cnt;
  logic                  active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame  <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      frame  <= build_frame(idx, arg);
      cnt    <= CNT_W'(FRAME_BITS - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign line_oe  = active;
  assign line_out = active ? frame[cnt] : 1'b1;
  assign done     = active && (cnt == '0);

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         long_i,
  input  logic         line_in,
  output logic         done,
  output logic         timed_out,
  output logic         crc_bad,
  output logic         end_bad,
  output logic [127:0] full
);
  localparam int WAIT_W = $clog2(TIMEOUT_CLKS);
  localparam int POS_W  = $clog2(LONG_BITS);

  logic              waiting, receiving, is_long;
  logic [WAIT_W-1:0] wcnt;
  logic [POS_W-1:0]  pos;
  logic [6:0]        crc;
  logic [126:0]      sh;
  logic              in_crc_span;

  assign in_crc_span = (pos >= POS_W'(8)) && (pos <= POS_W'(127));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      receiving <= 1'b0;
      is_long   <= 1'b0;
      wcnt      <= '0;
      pos       <= '0;
      crc       <= '0;
      sh        <= '0;
    end else if (start) begin
      waiting <= 1'b1;
      is_long <= long_i;
      wcnt    <= '0;
      sh      <= '0;
    end else if (waiting) begin
      if (!line_in) begin
        waiting   <= 1'b0;
        receiving <= 1'b1;
        pos       <= is_long ? POS_W'(LONG_BITS - 2) : POS_W'(SHORT_BITS - 2);
        // long responses leave the start bit out of the CRC span
        crc       <= is_long ? 7'd0 : crc7_next(7'd0, 1'b0);
      end else if (wcnt == WAIT_W'(TIMEOUT_CLKS - 1)) begin
        waiting <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (receiving) begin
      sh <= {sh[125:0], line_in};
      if (in_crc_span) crc <= crc7_next(crc, line_in);
      if (pos == '0) receiving <= 1'b0;
      else           pos       <= pos - 1'b1;
    end
  end

  assign full      = {sh, line_in};
  assign timed_out = waiting && line_in && (wcnt == WAIT_W'(TIMEOUT_CLKS - 1));
  assign done      = (receiving && (pos == '0)) || timed_out;
  assign crc_bad   = full[7:1] != crc;
  assign end_bad   = !line_in;

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64,
  parameter int PAD_CLKS     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic        resp_expect,
  input  logic        resp_long,
  input  logic        crc_ignore,
  input  logic        append8,
  input  logic        run,
  output logic        card_clk_en,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  output logic [31:0] resp_word0,
  output logic [31:0] resp_word1,
  output logic [31:0] resp_word2,
  output logic [31:0] resp_word3,
  output logic        cmd_busy,
  output logic        crc_err,
  output logic        end_err,
  output logic        timeout_err
);
  localparam int PAD_W = $clog2(PAD_CLKS + 1);

  eng_state_t       state;
  logic             want_resp, want_long, skip_crc, want_pad;
  logic [PAD_W-1:0] pad_cnt;

  logic         tx_done, rx_done, rx_timed_out, rx_crc_bad, rx_end_bad;
  logic [127:0] rx_full;

  // named events for the checker
  logic ev_accept, ev_rx_done, ev_xfer_end, pad_sel, skip_sel;

  assign ev_accept   = run && (state == ST_IDLE);
  assign ev_rx_done  = (state == ST_RESP) && rx_done;
  assign ev_xfer_end = ((state == ST_TX) && tx_done && !want_resp) || ev_rx_done;
  assign pad_sel     = want_pad;
  assign skip_sel    = skip_crc;

  sd_cmd_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev_accept),
    .idx      (cmd_index),
    .arg      (cmd_arg),
    .line_out (cmd_out),
    .line_oe  (cmd_oe),
    .done     (tx_done)
  );

  sd_cmd_rx #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     ((state == ST_TX) && tx_done && want_resp),
    .long_i    (want_long),
    .line_in   (cmd_in),
    .done      (rx_done),
    .timed_out (rx_timed_out),
    .crc_bad   (rx_crc_bad),
    .end_bad   (rx_end_bad),
    .full      (rx_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pad_cnt   <= '0;
      want_resp <= 1'b0;
      want_long <= 1'b0;
      skip_crc  <= 1'b0;
      want_pad  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (ev_accept) begin
          state     <= ST_TX;
          want_resp <= resp_expect;
          want_long <= resp_long;
          skip_crc  <= crc_ignore;
          want_pad  <= append8;
        end
        ST_TX: if (tx_done) begin
          if (want_resp)     state <= ST_RESP;
          else if (want_pad) state <= ST_PAD;
          else               state <= ST_IDLE;
        end
        ST_RESP: if (rx_done) state <= want_pad ? ST_PAD : ST_IDLE;
        ST_PAD: begin
          if (pad_cnt == PAD_W'(PAD_CLKS - 1)) begin
            state   <= ST_IDLE;
            pad_cnt <= '0;
          end else begin
            pad_cnt <= pad_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_err     <= 1'b0;
      end_err     <= 1'b0;
      timeout_err <= 1'b0;
      resp_word0  <= '0;
      resp_word1  <= '0;
      resp_word2  <= '0;
      resp_word3  <= '0;
    end else if (ev_accept) begin
      crc_err     <= 1'b0;
      end_err     <= 1'b0;
      timeout_err <= 1'b0;
    end else if (ev_rx_done) begin
      timeout_err <= rx_timed_out;
      crc_err     <= !rx_timed_out && !skip_crc && rx_crc_bad;
      end_err     <= !rx_timed_out && rx_end_bad;
      if (!rx_timed_out) begin
        if (want_long) begin
          resp_word0 <= rx_full[31:0];
          resp_word1 <= rx_full[63:32];
          resp_word2 <= rx_full[95:64];
          resp_word3 <= rx_full[127:96];
        end else begin
          resp_word0 <= rx_full[39:8];
          resp_word1 <= '0;
          resp_word2 <= '0;
          resp_word3 <= '0;
        end
      end
    end
  end

  assign cmd_busy    = (state != ST_IDLE);
  assign card_clk_en = (state != ST_IDLE);

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic cmd_busy,
  input logic cmd_oe,
  input logic cmd_out,
  input logic card_clk_en,
  input logic crc_err,
  input logic end_err,
  input logic timeout_err,
  input logic ev_rx_done,
  input logic ev_xfer_end,
  input logic pad_sel,
  input logic skip_sel
);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> $past(run));

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> (cmd_oe && !cmd_out));

  // R2
  oe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_busy);

  // R10
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_end && pad_sel) |=> (card_clk_en && !cmd_oe));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer_end && !pad_sel) |=> !cmd_busy);

  // R6
  crc_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && skip_sel) |=> !crc_err);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !(crc_err || end_err));

endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .cmd_busy    (cmd_busy),
  .cmd_oe      (cmd_oe),
  .cmd_out     (cmd_out),
  .card_clk_en (card_clk_en),
  .crc_err     (crc_err),
  .end_err     (end_err),
  .timeout_err (timeout_err),
  .ev_rx_done  (ev_rx_done),
  .ev_xfer_end (ev_xfer_end),
  .pad_sel     (pad_sel),
  .skip_sel    (skip_sel)
);

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        resp_expect = 1'b0, resp_long = 1'b0, crc_ignore = 1'b0, append8 = 1'b0;
  logic        run = 1'b0;
  logic        cmd_in = 1'b1;
  logic        card_clk_en, cmd_out, cmd_oe, cmd_busy, crc_err, end_err, timeout_err;
  logic [31:0] resp_word0, resp_word1, resp_word2, resp_word3;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine u_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .resp_expect(resp_expect), .resp_long(resp_long), .crc_ignore(crc_ignore),
    .append8(append8), .run(run), .card_clk_en(card_clk_en), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in), .resp_word0(resp_word0), .resp_word1(resp_word1),
    .resp_word2(resp_word2), .resp_word3(resp_word3), .cmd_busy(cmd_busy),
    .crc_err(crc_err), .end_err(end_err), .timeout_err(timeout_err)
  );

  typedef struct {
    logic [47:0]  frame;
    int           clocks;
    logic [127:0] words;
    logic [2:0]   flags;   // {timeout, end, crc}
    string        tag;
  } exp_t;

  exp_t         q[$];
  logic [127:0] model_words = '0;

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // bitwise long division, MSB first, by 0x89
  function automatic logic [6:0] ref_crc(input logic [127:0] v, input int n);
    logic [7:0] r;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      r = {r[6:0], v[i]};
      if (r[7]) r = r ^ 8'h89;
    end
    for (int k = 0; k < 7; k++) begin
      r = {r[6:0], 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  // monitor: collects frame and clock count, compares when busy drops
  initial begin
    logic [47:0] cap;
    int          clocks;
    logic        prev_busy;
    exp_t        e;
    cap = '0; clocks = 0; prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (cmd_busy && card_clk_en) clocks++;
      if (cmd_oe) cap = {cap[46:0], cmd_out};
      if (prev_busy && !cmd_busy) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11 unexpected completion", 128'(clocks), 0);
        end else begin
          e = q.pop_front();
          chk(cap == e.frame, {e.tag, " R1 frame"}, 128'(cap), 128'(e.frame));
          chk(clocks == e.clocks, {e.tag, " R9 clocks"}, 128'(clocks), 128'(e.clocks));
          chk(resp_word0 == e.words[31:0], {e.tag, " word0"}, 128'(resp_word0), 128'(e.words[31:0]));
          chk(resp_word1 == e.words[63:32], {e.tag, " word1"}, 128'(resp_word1), 128'(e.words[63:32]));
          chk(resp_word2 == e.words[95:64], {e.tag, " word2"}, 128'(resp_word2), 128'(e.words[95:64]));
          chk(resp_word3 == e.words[127:96], {e.tag, " word3"}, 128'(resp_word3), 128'(e.words[127:96]));
          chk(crc_err == e.flags[0], {e.tag, " crc_err"}, 128'(crc_err), 128'(e.flags[0]));
          chk(end_err == e.flags[1], {e.tag, " end_err"}, 128'(end_err), 128'(e.flags[1]));
          chk(timeout_err == e.flags[2], {e.tag, " timeout_err"}, 128'(timeout_err), 128'(e.flags[2]));
        end
        clocks = 0;
        cap = '0;
      end
      prev_busy = cmd_busy;
    end
  end

  // driver: pushes the expectation, starts the command and plays the card
  task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg,
                        input logic rexp, input logic rlong, input logic ign,
                        input logic app8, input int delay, input logic bad_crc,
                        input logic bad_end, input logic [119:0] payload,
                        input int extra_run, input string tag);
    exp_t         e;
    logic [39:0]  head, body;
    logic [6:0]   c;
    logic [135:0] rb;
    int           nbits;
    logic         got;
    head    = {2'b01, idx, arg};
    e.frame = {head, ref_crc(128'(head), 40), 1'b1};
    e.tag   = tag;
    got     = rexp && (delay >= 0);
    if (rlong) begin
      c     = ref_crc(128'(payload), 120) ^ {6'd0, bad_crc};
      rb    = {2'b00, 6'h3F, payload, c, !bad_end};
      nbits = 136;
      if (got) model_words = {payload, c, !bad_end};
    end else begin
      body  = {2'b00, idx, payload[31:0]};
      c     = ref_crc(128'(body), 40) ^ {6'd0, bad_crc};
      rb    = {body, c, !bad_end, 88'd0};
      nbits = 48;
      if (got) model_words = {96'd0, payload[31:0]};
    end
    e.clocks = 48 + (rexp ? (got ? delay + nbits : 64) : 0) + (app8 ? 8 : 0);
    e.words  = model_words;
    e.flags  = {rexp && !got, got && bad_end, got && bad_crc && !ign};
    q.push_back(e);

    cmd_index = idx; cmd_arg = arg; resp_expect = rexp; resp_long = rlong;
    crc_ignore = ign; append8 = app8; run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    if (extra_run > 0) begin
      repeat (extra_run) @(negedge clk);
      cmd_index = ~idx; cmd_arg = ~arg; resp_expect = 1'b0; run = 1'b1;
      @(negedge clk);
      run = 1'b0;
    end
    if (got) begin
      while (cmd_oe) @(negedge clk);
      repeat (delay) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
        cmd_in = rb[135 - i];
        @(negedge clk);
      end
      cmd_in = 1'b1;
    end
    while (cmd_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_busy && !card_clk_en && !cmd_oe, "R9 reset idle", 128'({cmd_busy, card_clk_en, cmd_oe}), 0);
    chk({crc_err, end_err, timeout_err} == 3'b000, "R12 reset flags", 128'({crc_err, end_err, timeout_err}), 0);
    chk({resp_word0, resp_word1, resp_word2, resp_word3} == '0, "R3 reset words", 128'(resp_word0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_cmd(6'd0, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, '0, 0, "R2 noresp zero");
    do_cmd(6'h2A, 32'hA5A5_0F0F, 0, 0, 0, 1, 0, 0, 0, '0, 0, "R10 noresp pad");
    do_cmd(6'd17, 32'h1234_5678, 1, 0, 0, 0, 2, 0, 0, 120'h0000_0900, 0, "R3 short");
    do_cmd(6'd55, 32'hFFFF_FFFF, 1, 0, 0, 0, 63, 0, 0, 120'hDEAD_BEEF, 0, "R8 last slot");
    do_cmd(6'd2, 32'h0, 1, 1, 0, 0, 5, 0, 0,
           120'h1F_2E3D_4C5B_6A79_8897_A6B5_C4D3_E2F1, 0, "R4 long");
    do_cmd(6'd13, 32'h0001_0000, 1, 0, 0, 0, 1, 1, 0, 120'h0000_0B00, 0, "R5 bad crc");
    do_cmd(6'd41, 32'h00FF_8000, 1, 0, 1, 0, 3, 1, 0, 120'h80FF_8000, 0, "R6 ignore crc");
    do_cmd(6'd9, 32'h0002_0000, 1, 1, 1, 0, 0, 1, 0,
           120'hAB_CDEF_0123_4567_89AB_CDEF_0011_2233, 0, "R6 long ignore");
    do_cmd(6'd7, 32'h0003_0000, 1, 1, 0, 0, 4, 0, 1,
           120'h55_AA55_AA55_AA55_AA55_AA55_AA55_AA55, 0, "R7 long end");
    do_cmd(6'd8, 32'h0000_01AA, 1, 0, 0, 0, -1, 0, 0, '0, 0, "R8 timeout");
    do_cmd(6'd0, 32'h0, 0, 0, 0, 0, 0, 0, 0, '0, 0, "R12 clear");
    do_cmd(6'd3, 32'h0, 1, 0, 0, 1, 0, 1, 1, 120'h0000_0520, 0, "R5 R7 both pad");
    do_cmd(6'd12, 32'h0, 1, 0, 0, 1, -1, 0, 0, '0, 0, "R8 R10 timeout pad");
    do_cmd(6'd16, 32'h0000_0200, 1, 0, 0, 0, 2, 0, 0, 120'h0000_0900, 10, "R11 run busy");
    repeat (3) begin
      chk(!cmd_busy && !cmd_oe, "R11 no second command", 128'({cmd_busy, cmd_oe}), 0);
      @(negedge clk);
    end
    chk(q.size() == 0, "R9 all completions seen", 128'(q.size()), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule